// File: doc/BRIEF.md
# Receive Frame Length Counter

This block sits beside the receive FIFO of a serial-link receiver. It counts the bytes of the frame now arriving. When the frame closes, it captures the length and an overflow indication into two byte-wide status words that software can read. It then raises a one-cycle end-of-frame interrupt and reports how many bytes of that frame are still waiting in the FIFO.

The captured values stay frozen until software acknowledges the frame. A second frame may close before that acknowledge. Its result is parked in one pending slot and is presented, with a fresh interrupt, on the acknowledge edge.

The FIFO threshold is given as a power-of-two exponent. The leftover byte count is therefore the low bits of the length. When those low bits are zero, the leftover count is one full threshold.

Top module: `rx_frame_len`

## Requirements
- R1: While reset is asserted and right after it, `stat_lo` and `stat_hi` read 00h, `eof_irq` is 0 and `fifo_left` is 0.
- R2: Each cycle with `byte_vld` high adds one byte to the current frame, including a byte in the same cycle as `frame_end`. When a frame closes with nothing captured, the next edge loads `stat_lo` = length bits 7..0 and `stat_hi` bits 4..0 = length bits 12..8. `stat_hi` bits 6..5 always read 0.
- R3: A frame of 8192 bytes or more sets `stat_hi` bit 7, and its length field reads 1FFFh (saturated). A frame of exactly 8191 bytes leaves bit 7 clear.
- R4: While a frame is captured and not acknowledged, further bytes and frame ends do not change `stat_lo` or `stat_hi`.
- R5: `rx_ack` with a captured frame and nothing pending clears both status words to 00h, including the overflow bit. `rx_ack` with nothing captured has no effect.
- R6: `eof_irq` is high for exactly one cycle per loaded frame: the first cycle in which that frame's values appear on the status outputs.
- R7: The first byte of a new frame restarts the count at 1. Overflow from an earlier frame is not carried over.
- R8: With a frame captured, `fifo_left` = length mod 2^k, where k = min(`thr_sel`, 6). It reads 2^k when that remainder is 0. With nothing captured it reads 0.
- R9: A frame end while a frame is captured is held pending. On `rx_ack` the pending values load at that edge, with an interrupt. A later frame end while one is already pending replaces it.
- R10: A frame end with no byte received since the previous frame end loads nothing and raises no interrupt.
- R11: When `rx_ack` and a frame end fall in the same cycle, with a frame captured and nothing pending, the new frame loads directly at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One received byte of the current frame |
| frame_end | input | 1 | Current frame closes this cycle |
| rx_ack | input | 1 | Software acknowledges the captured frame |
| thr_sel | input | 3 | FIFO threshold exponent (threshold = 2^min(thr_sel,6)) |
| stat_lo | output | 8 | Captured length bits 7..0 |
| stat_hi | output | 8 | Bit 7 overflow, bits 6..5 zero, bits 4..0 length bits 12..8 |
| eof_irq | output | 1 | One-cycle end-of-frame interrupt |
| fifo_left | output | 7 | Bytes of the captured frame left in the FIFO |

## Verification
A wrong running count stays hidden until the frame closes. It then appears in the status words on the very next edge. A wrong captured or pending state shows up at once as moved status words, a missing or doubled interrupt, or a nonzero `fifo_left` with nothing captured. The threshold path is combinational, so an error there is visible in the same cycle that `thr_sel` changes. The overflow bit can only be exercised with frames long enough to reach saturation, so the stimulus runs past 8191 and 8192 bytes.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int LEN_W = 13;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  typedef struct packed {
    logic             ovf;
    logic [LEN_W-1:0] len;
  } frame_rec_t;
endpackage

// File: rtl/flc_run_count.sv
module flc_run_count
  import flc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic       frame_end,
  output logic       end_vld_o,
  output frame_rec_t end_rec_o
);
  logic             fresh_q, fresh_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             upd_en;

  assign upd_en = byte_vld | frame_end;

  always_comb begin
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    fresh_d = fresh_q;
    if (byte_vld) begin
      if (fresh_q) begin
        cnt_d = LEN_W'(1);
        ovf_d = 1'b0;
      end else if (cnt_q == LEN_MAX) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (frame_end) begin
      fresh_d = 1'b1;
    end else if (byte_vld) begin
      fresh_d = 1'b0;
    end
  end

  // an empty frame (no byte since the last end) is not reported
  assign end_vld_o = frame_end & ~(fresh_q & ~byte_vld);
  assign end_rec_o = '{ovf: ovf_d, len: cnt_d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b1;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (upd_en) begin
      fresh_q <= fresh_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
    end
  end

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh_q && byte_vld) |=> (cnt_q == LEN_W'(1) && !ovf_q));

  assert_sat_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == LEN_MAX));
endmodule

// File: rtl/flc_status_hold.sv
module flc_status_hold
  import flc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       end_vld_i,
  input  frame_rec_t end_rec_i,
  input  logic       ack_i,
  output logic       held_o,
  output frame_rec_t stat_o,
  output logic       irq_o
);
  logic       held_q, held_d;
  frame_rec_t stat_q, stat_d;
  logic       pv_q, pv_d;
  frame_rec_t pend_q, pend_d;
  logic       irq_q, irq_d;
  logic       upd_en;

  assign upd_en = ack_i | end_vld_i;

  always_comb begin
    held_d = held_q;
    stat_d = stat_q;
    pv_d   = pv_q;
    pend_d = pend_q;
    irq_d  = 1'b0;
    if (ack_i && held_q) begin
      if (pv_q) begin
        stat_d = pend_q;
        irq_d  = 1'b1;
        pv_d   = end_vld_i;
        if (end_vld_i) pend_d = end_rec_i;
      end else if (end_vld_i) begin
        stat_d = end_rec_i;
        irq_d  = 1'b1;
      end else begin
        held_d = 1'b0;
        stat_d = '0;
      end
    end else if (end_vld_i) begin
      if (held_q) begin
        pend_d = end_rec_i;
        pv_d   = 1'b1;
      end else begin
        held_d = 1'b1;
        stat_d = end_rec_i;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      stat_q <= '0;
      pv_q   <= 1'b0;
      pend_q <= '0;
    end else if (upd_en) begin
      held_q <= held_d;
      stat_q <= stat_d;
      pv_q   <= pv_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign held_o = held_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  assert_irq_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> held_q);

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !ack_i) |=> $stable(stat_q));

  assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !held_q |-> (stat_q == '0 && !pv_q));

  assert_pend_needs_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> held_q);
endmodule

// File: rtl/flc_fifo_rem.sv
module flc_fifo_rem
  import flc_pkg::*;
#(
  parameter int MAX_THR_LOG2 = 6,
  parameter int THR_SEL_W    = 3,
  localparam int LEFT_W      = MAX_THR_LOG2 + 1
) (
  input  logic                 held_i,
  input  logic [LEN_W-1:0]     len_i,
  input  logic [THR_SEL_W-1:0] thr_sel_i,
  output logic [LEFT_W-1:0]    left_o
);
  logic [THR_SEL_W-1:0] thr_log;
  logic [LEFT_W-1:0]    thr_val;
  logic [LEFT_W-1:0]    len_low;
  logic [LEFT_W-1:0]    rem;

  always_comb begin
    if (int'(thr_sel_i) > MAX_THR_LOG2) thr_log = THR_SEL_W'(MAX_THR_LOG2);
    else                                thr_log = thr_sel_i;
  end

  assign thr_val = LEFT_W'(1) << thr_log;
  assign len_low = LEFT_W'(len_i[MAX_THR_LOG2-1:0]);
  assign rem     = len_low & (thr_val - LEFT_W'(1));

  always_comb begin
    if (!held_i || len_i == '0) left_o = '0;
    else if (rem == '0)         left_o = thr_val;
    else                        left_o = rem;
  end
endmodule

// File: rtl/rx_frame_len.sv
module rx_frame_len
  import flc_pkg::*;
#(
  parameter int MAX_THR_LOG2 = 6,
  parameter int THR_SEL_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic                  frame_end,
  input  logic                  rx_ack,
  input  logic [THR_SEL_W-1:0]  thr_sel,
  output logic [7:0]            stat_lo,
  output logic [7:0]            stat_hi,
  output logic                  eof_irq,
  output logic [MAX_THR_LOG2:0] fifo_left
);
  logic       end_vld;
  frame_rec_t end_rec;
  logic       held;
  frame_rec_t stat;

  flc_run_count u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .frame_end (frame_end),
    .end_vld_o (end_vld),
    .end_rec_o (end_rec)
  );

  flc_status_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_vld_i (end_vld),
    .end_rec_i (end_rec),
    .ack_i     (rx_ack),
    .held_o    (held),
    .stat_o    (stat),
    .irq_o     (eof_irq)
  );

  flc_fifo_rem #(
    .MAX_THR_LOG2 (MAX_THR_LOG2),
    .THR_SEL_W    (THR_SEL_W)
  ) u_rem (
    .held_i    (held),
    .len_i     (stat.len),
    .thr_sel_i (thr_sel),
    .left_o    (fifo_left)
  );

  assign stat_lo = stat.len[7:0];
  assign stat_hi = {stat.ovf, 2'b00, stat.len[12:8]};

  assert_ovf_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_hi[7] |-> ({stat_hi[4:0], stat_lo} == 13'h1FFF));

  assert_left_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lo == 8'h00 && stat_hi == 8'h00) |-> (fifo_left == '0));

  assert_left_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_lo != 8'h00 || stat_hi != 8'h00) |-> (fifo_left != '0));
endmodule

// File: tb/sim_rx_frame_len.sv
`timescale 1ns/1ps
module sim_rx_frame_len;
  logic       clk;
  logic       rst_n;
  logic       byte_vld, frame_end, rx_ack;
  logic [2:0] thr_sel;
  logic [7:0] stat_lo, stat_hi;
  logic       eof_irq;
  logic [6:0] fifo_left;

  int n_total = 0;
  int n_bad   = 0;
  string tag  = "R1";

  // behavioural model state
  int m_fresh = 1, m_cnt = 0, m_ovf = 0;
  int m_held = 0, m_len = 0, m_hovf = 0;
  int m_pv = 0, m_plen = 0, m_povf = 0;
  int m_irq = 0;

  int obs_lo, obs_hi, obs_irq, obs_left;

  rx_frame_len u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .frame_end (frame_end),
    .rx_ack    (rx_ack),
    .thr_sel   (thr_sel),
    .stat_lo   (stat_lo),
    .stat_hi   (stat_hi),
    .eof_irq   (eof_irq),
    .fifo_left (fifo_left)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_left();
    int k, t, r;
    if (m_held == 0 || m_len == 0) return 0;
    k = (int'(thr_sel) > 6) ? 6 : int'(thr_sel);
    t = 1 << k;
    r = m_len % t;
    return (r == 0) ? t : r;
  endfunction

  task automatic compare();
    int e_lo, e_hi;
    e_lo = m_len & 255;
    e_hi = (m_hovf << 7) | (m_len >> 8);
    obs_lo = int'(stat_lo); obs_hi = int'(stat_hi);
    obs_irq = int'(eof_irq); obs_left = int'(fifo_left);
    n_total++;
    if (obs_lo != e_lo || obs_hi != e_hi || obs_irq != m_irq || obs_left != exp_left()) begin
      n_bad++;
      $display("FAIL %s per-cycle: actual lo=%0h hi=%0h irq=%0d left=%0d expected lo=%0h hi=%0h irq=%0d left=%0d",
               tag, obs_lo, obs_hi, obs_irq, obs_left, e_lo, e_hi, m_irq, exp_left());
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_edge(input int bv, input int fe, input int ak);
    int empty, endv;
    empty = (m_fresh != 0 && bv == 0) ? 1 : 0;
    if (bv != 0) begin
      if (m_fresh != 0) begin m_cnt = 1; m_ovf = 0; end
      else if (m_cnt == 8191) m_ovf = 1;
      else m_cnt++;
    end
    endv = (fe != 0 && empty == 0) ? 1 : 0;
    if (fe != 0) m_fresh = 1;
    else if (bv != 0) m_fresh = 0;
    m_irq = 0;
    if (ak != 0 && m_held != 0) begin
      if (m_pv != 0) begin
        m_len = m_plen; m_hovf = m_povf; m_irq = 1; m_pv = 0;
        if (endv != 0) begin m_plen = m_cnt; m_povf = m_ovf; m_pv = 1; end
      end else if (endv != 0) begin
        m_len = m_cnt; m_hovf = m_ovf; m_irq = 1;
      end else begin
        m_held = 0; m_len = 0; m_hovf = 0;
      end
    end else if (endv != 0) begin
      if (m_held != 0) begin m_plen = m_cnt; m_povf = m_ovf; m_pv = 1; end
      else begin m_held = 1; m_len = m_cnt; m_hovf = m_ovf; m_irq = 1; end
    end
  endtask

  task automatic step(input logic bv, input logic fe, input logic ak);
    @(negedge clk);
    compare();
    byte_vld = bv; frame_end = fe; rx_ack = ak;
    @(posedge clk);
    model_edge(int'(bv), int'(fe), int'(ak));
  endtask

  task automatic frame_bytes(input int n, input bit end_on_last);
    for (int i = 0; i < n; i++) step(1'b1, end_on_last && (i == n - 1), 1'b0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_vld = 1'b0; frame_end = 1'b0; rx_ack = 1'b0; thr_sel = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 lo in reset", int'(stat_lo), 0);
    chk("R1 hi in reset", int'(stat_hi), 0);
    chk("R1 irq in reset", int'(eof_irq), 0);
    chk("R1 left in reset", int'(fifo_left), 0);
    rst_n = 1'b1;
    step(0, 0, 0);
    step(0, 0, 0);
    chk("R1 lo after reset", obs_lo, 0);

    // R2 / R6: 5 bytes, frame end with the last byte
    tag = "R2";
    frame_bytes(5, 1'b1);
    step(0, 0, 0);
    chk("R2 lo=5", obs_lo, 5);
    chk("R2 hi=0", obs_hi, 0);
    chk("R6 irq on load", obs_irq, 1);
    step(0, 0, 0);
    chk("R6 irq single cycle", obs_irq, 0);

    // R8: threshold remainder
    tag = "R8";
    chk("R8 thr=1 full", obs_left, 1);
    thr_sel = 3'd2;
    step(0, 0, 0);
    chk("R8 5 mod 4", obs_left, 1);
    thr_sel = 3'd7;
    step(0, 0, 0);
    chk("R8 clamp to 64", obs_left, 5);
    thr_sel = 3'd3;

    // R4: frozen while held; R9: pending replaced then loaded on ack
    tag = "R4";
    frame_bytes(3, 1'b1);
    step(0, 0, 0);
    chk("R4 lo unchanged", obs_lo, 5);
    chk("R4 no irq", obs_irq, 0);
    tag = "R9";
    frame_bytes(2, 1'b1);
    step(0, 0, 1);
    step(0, 0, 0);
    chk("R9 pending replaced and loaded", obs_lo, 2);
    chk("R9 irq on ack load", obs_irq, 1);
    chk("R8 2 mod 8", obs_left, 2);

    // R5: ack clears, ack without frame ignored
    tag = "R5";
    step(0, 0, 1);
    step(0, 0, 0);
    chk("R5 lo cleared", obs_lo, 0);
    chk("R5 hi cleared", obs_hi, 0);
    chk("R8 idle left", obs_left, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    chk("R5 idle ack lo", obs_lo, 0);
    chk("R5 idle ack irq", obs_irq, 0);

    // R10: empty frame end ignored
    tag = "R10";
    step(0, 1, 0);
    step(0, 0, 0);
    chk("R10 no irq", obs_irq, 0);
    chk("R10 no load", obs_lo, 0);

    // R2: frame end in a cycle without a byte, 300 bytes
    tag = "R2";
    frame_bytes(300, 1'b0);
    step(0, 1, 0);
    step(0, 0, 0);
    chk("R2 lo of 300", obs_lo, 44);
    chk("R2 hi of 300", obs_hi, 1);
    chk("R8 300 mod 8", obs_left, 4);
    thr_sel = 3'd2;
    step(0, 0, 0);
    chk("R8 300 mod 4 full", obs_left, 4);

    // R11: ack and frame end together
    tag = "R11";
    frame_bytes(2, 1'b0);
    step(1, 1, 1);
    step(0, 0, 0);
    chk("R11 direct load", obs_lo, 3);
    chk("R11 irq", obs_irq, 1);

    // R3: 8191 no overflow, 8192 overflow, R7 restart
    tag = "R3";
    step(0, 0, 1);
    frame_bytes(8191, 1'b1);
    step(0, 0, 0);
    chk("R3 8191 lo", obs_lo, 8'hFF);
    chk("R3 8191 hi", obs_hi, 8'h1F);
    step(0, 0, 1);
    frame_bytes(8192, 1'b1);
    step(0, 0, 0);
    chk("R3 8192 hi ovf", obs_hi, 8'h9F);
    chk("R3 8192 lo sat", obs_lo, 8'hFF);
    chk("R8 8191 mod 4", obs_left, 3);
    tag = "R7";
    step(0, 0, 1);
    frame_bytes(1, 1'b1);
    step(0, 0, 0);
    chk("R7 restart lo", obs_lo, 1);
    chk("R7 ovf not carried", obs_hi, 0);
    step(0, 0, 0);

    summary();
    $finish;
  end
endmodule